// File: doc/BRIEF.md
# Serial Port Core with Status Flags and Interrupt Requests

This block is the data path of an asynchronous serial port. A transmit holding register feeds a transmit shift register, and a receive shift register feeds a receive data register. Each bit lasts a fixed number of ticks of an externally supplied oversampling tick. Three status flags track the block's state. The first shows that the holding register can take a new byte. The second shows that received data is waiting. The third is set on an overrun or a framing error.

Two interrupt request lines follow the flags, and each line has its own enable. The host writes, reads and clears through single-cycle strobes. A control strobe loads both interrupt enables and the frame mode. In the nine-bit mode the receiver passes a frame to the flags only when its ninth bit is 1, which lets a node ignore traffic meant for other nodes. A framing error is still reported in that mode.

Top module: `sfi_uart`

## Requirements
- R1: After reset, tdre is 1, rdrf and orfe are 0, both interrupt requests are 0 and txd is 1.
- R2: A tx_wr strobe makes tdre read 0 after the next clock edge. If the shifter is idle, the next edge moves the byte into the shifter, sets tdre back to 1 and drives the start bit.
- R3: A transmitted frame is one start bit at 0, then the data bits least significant first (bits 7:0, or bits 8:0 when ctrl_m9 is set), then one stop bit at 1. Each bit lasts OVS baud ticks, and txd is 1 when idle.
- R4: irq_tx is 1 exactly when tdre is 1 and the transmit enable loaded through ctrl_tie is 1.
- R5: A frame with a valid stop bit sets rdrf and updates rx_data (data in bits 7:0, bit 8 = 0 in eight-bit mode). This happens only once the stop bit has been sampled at its centre. The flags do not change earlier in the frame.
- R6: A stop bit sampled as 0 sets orfe. It leaves rdrf and rx_data unchanged.
- R7: A valid frame that completes while rdrf is 1 sets orfe. The old rx_data is kept and the new frame is dropped.
- R8: With ctrl_m9 set, a valid frame whose ninth bit (rx_data bit 8) is 0 changes no flag and no data. A frame whose ninth bit is 1 sets rdrf.
- R9: With ctrl_m9 set, a framing error sets orfe whatever the value of the ninth bit.
- R10: rx_rd clears rdrf. orfe clears only on an rx_rd that follows a stat_rd strobe issued while orfe was 1. An rx_rd on its own leaves orfe set.
- R11: irq_rx is 1 exactly when (rdrf or orfe) is 1 and the receive enable loaded through ctrl_rie is 1.
- R12: A low pulse on rxd shorter than OVS/2 ticks does not start a frame. After such a pulse, the next real frame is received correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| baud_tick | input | 1 | Oversampling tick, OVS ticks per bit |
| ctrl_wr | input | 1 | Loads the enables and the mode |
| ctrl_tie | input | 1 | Transmit interrupt enable value |
| ctrl_rie | input | 1 | Receive interrupt enable value |
| ctrl_m9 | input | 1 | Nine-bit mode value |
| tx_wr | input | 1 | Write strobe for the holding register |
| tx_data | input | 9 | Byte to send, bit 8 used in nine-bit mode |
| stat_rd | input | 1 | Status read strobe, arms the error clear |
| rx_rd | input | 1 | Receive data read strobe |
| rxd | input | 1 | Serial input |
| txd | output | 1 | Serial output |
| tdre | output | 1 | Holding register empty |
| rdrf | output | 1 | Received data waiting |
| orfe | output | 1 | Overrun or framing error |
| rx_data | output | 9 | Receive data register |
| irq_tx | output | 1 | Transmit interrupt request |
| irq_rx | output | 1 | Receive interrupt request |

## Verification
Strobes (control, reads, holding write) take effect at the first clock edge that samples them. The bench drives and samples on the falling edge, so each such result is checked half a cycle after that edge, and the holding-to-shifter move is checked one cycle later. Transmit bits are sampled at the middle of each OVS-tick period counted from the cycle the start bit appears, which tolerates the phase of the baud tick. Receive flags move two synchroniser cycles plus half a bit after the stop edge. The bench therefore checks that nothing has moved four cycles into the stop bit, and checks the new flags once the stop bit has ended.

// File: rtl/sfi_pkg.sv
package sfi_pkg;

    typedef enum logic [1:0] {
        RX_IDLE  = 2'd0,
        RX_START = 2'd1,
        RX_DATA  = 2'd2,
        RX_STOP  = 2'd3
    } rx_state_e;

endpackage

// File: rtl/sfi_tx.sv
module sfi_tx #(
    parameter int DW  = 8,
    parameter int OVS = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          m9,
    input  logic          wr,
    input  logic [DW:0]   wdata,
    output logic          txd,
    output logic          tdre
);
    localparam int CW = $clog2(OVS);
    localparam int SW = DW + 3;
    localparam int BW = $clog2(SW + 1);

    typedef struct packed {
        logic [DW:0]    hold;
        logic           full;
        logic           busy;
        logic [SW-1:0]  sh;
        logic [BW-1:0]  left;
        logic [CW-1:0]  cnt;
    } tx_s;

    tx_s tx_d, tx_q;

    always_comb begin
        tx_d = tx_q;
        if (!tx_q.busy && tx_q.full) begin
            tx_d.sh   = {1'b1, (m9 ? tx_q.hold[DW] : 1'b1), tx_q.hold[DW-1:0], 1'b0};
            tx_d.left = m9 ? BW'(SW) : BW'(SW - 1);
            tx_d.cnt  = '0;
            tx_d.busy = 1'b1;
            tx_d.full = 1'b0;
        end else if (tx_q.busy && tick) begin
            if (tx_q.cnt == CW'(OVS - 1)) begin
                tx_d.cnt  = '0;
                tx_d.sh   = {1'b1, tx_q.sh[SW-1:1]};
                tx_d.left = tx_q.left - BW'(1);
                if (tx_q.left == BW'(1)) tx_d.busy = 1'b0;
            end else begin
                tx_d.cnt = tx_q.cnt + CW'(1);
            end
        end
        if (wr) begin
            tx_d.hold = wdata;
            tx_d.full = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tx_q <= '0;
        else        tx_q <= tx_d;
    end

    assign txd  = tx_q.busy ? tx_q.sh[0] : 1'b1;
    assign tdre = ~tx_q.full;

    // holding register moves into an idle shifter on the next edge
    assert_hold_to_shift_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_q.busy && tx_q.full && !wr) |=> (tx_q.busy && !tx_q.full));

    // the last bit put out before going idle is the stop bit
    assert_stop_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_q.busy) |-> $past(txd));

endmodule

// File: rtl/sfi_rx.sv
module sfi_rx
    import sfi_pkg::*;
#(
    parameter int DW  = 8,
    parameter int OVS = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          m9,
    input  logic          rxd,
    output logic          done,
    output logic          stop_ok,
    output logic [DW:0]   frame
);
    localparam int CW = $clog2(OVS);
    localparam int BW = $clog2(DW + 2);

    typedef struct packed {
        logic           s1;
        logic           s2;
        rx_state_e      st;
        logic [CW-1:0]  cnt;
        logic [BW-1:0]  idx;
        logic [DW:0]    sh;
        logic           done;
        logic           stop_ok;
        logic [DW:0]    data;
    } rx_s;

    rx_s rx_d, rx_q;

    always_comb begin
        rx_d      = rx_q;
        rx_d.s1   = rxd;
        rx_d.s2   = rx_q.s1;
        rx_d.done = 1'b0;
        if (tick) begin
            unique case (rx_q.st)
                RX_IDLE: begin
                    if (!rx_q.s2) begin
                        rx_d.st  = RX_START;
                        rx_d.cnt = '0;
                    end
                end
                RX_START: begin
                    if (rx_q.s2) begin
                        rx_d.st = RX_IDLE;
                    end else if (rx_q.cnt == CW'(OVS / 2 - 1)) begin
                        rx_d.st  = RX_DATA;
                        rx_d.cnt = '0;
                        rx_d.idx = '0;
                        rx_d.sh  = '0;
                    end else begin
                        rx_d.cnt = rx_q.cnt + CW'(1);
                    end
                end
                RX_DATA: begin
                    if (rx_q.cnt == CW'(OVS - 1)) begin
                        rx_d.cnt = '0;
                        rx_d.sh  = {rx_q.s2, rx_q.sh[DW:1]};
                        rx_d.idx = rx_q.idx + BW'(1);
                        if (rx_q.idx == (m9 ? BW'(DW) : BW'(DW - 1))) rx_d.st = RX_STOP;
                    end else begin
                        rx_d.cnt = rx_q.cnt + CW'(1);
                    end
                end
                RX_STOP: begin
                    if (rx_q.cnt == CW'(OVS - 1)) begin
                        rx_d.done    = 1'b1;
                        rx_d.stop_ok = rx_q.s2;
                        rx_d.data    = m9 ? rx_q.sh : {1'b0, rx_q.sh[DW:1]};
                        rx_d.st      = RX_IDLE;
                    end else begin
                        rx_d.cnt = rx_q.cnt + CW'(1);
                    end
                end
                default: rx_d.st = RX_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_q    <= '0;
            rx_q.s1 <= 1'b1;
            rx_q.s2 <= 1'b1;
        end else begin
            rx_q <= rx_d;
        end
    end

    assign done    = rx_q.done;
    assign stop_ok = rx_q.stop_ok;
    assign frame   = rx_q.data;

    // a line that returns high before start confirmation drops back to idle
    assert_glitch_reject_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_q.st == RX_START && tick && rx_q.s2) |=> (rx_q.st == RX_IDLE));

    // a completed frame is reported for one cycle only
    assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rx_q.done |=> !rx_q.done);

endmodule

// File: rtl/sfi_uart.sv
module sfi_uart #(
    parameter int DW  = 8,
    parameter int OVS = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          baud_tick,
    input  logic          ctrl_wr,
    input  logic          ctrl_tie,
    input  logic          ctrl_rie,
    input  logic          ctrl_m9,
    input  logic          tx_wr,
    input  logic [DW:0]   tx_data,
    input  logic          stat_rd,
    input  logic          rx_rd,
    input  logic          rxd,
    output logic          txd,
    output logic          tdre,
    output logic          rdrf,
    output logic          orfe,
    output logic [DW:0]   rx_data,
    output logic          irq_tx,
    output logic          irq_rx
);
    typedef struct packed {
        logic           tie;
        logic           rie;
        logic           m9;
        logic           rdrf;
        logic           orfe;
        logic           arm;
        logic [DW:0]    rdr;
    } fl_s;

    fl_s fl_d, fl_q;

    logic          rx_done;
    logic          rx_ok;
    logic [DW:0]   rx_frame;
    logic          accept;

    sfi_tx #(.DW(DW), .OVS(OVS)) u_tx (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (baud_tick),
        .m9    (fl_q.m9),
        .wr    (tx_wr),
        .wdata (tx_data),
        .txd   (txd),
        .tdre  (tdre)
    );

    sfi_rx #(.DW(DW), .OVS(OVS)) u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (baud_tick),
        .m9      (fl_q.m9),
        .rxd     (rxd),
        .done    (rx_done),
        .stop_ok (rx_ok),
        .frame   (rx_frame)
    );

    assign accept = !fl_q.m9 || rx_frame[DW];

    always_comb begin
        fl_d = fl_q;
        if (ctrl_wr) begin
            fl_d.tie = ctrl_tie;
            fl_d.rie = ctrl_rie;
            fl_d.m9  = ctrl_m9;
        end
        if (stat_rd && fl_q.orfe) fl_d.arm = 1'b1;
        if (rx_rd) begin
            fl_d.rdrf = 1'b0;
            if (fl_q.arm) fl_d.orfe = 1'b0;
            fl_d.arm = 1'b0;
        end
        if (rx_done) begin
            if (!rx_ok) begin
                fl_d.orfe = 1'b1;
            end else if (accept) begin
                if (fl_q.rdrf) begin
                    fl_d.orfe = 1'b1;
                end else begin
                    fl_d.rdrf = 1'b1;
                    fl_d.rdr  = rx_frame;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fl_q <= '0;
        else        fl_q <= fl_d;
    end

    assign rdrf    = fl_q.rdrf;
    assign orfe    = fl_q.orfe;
    assign rx_data = fl_q.rdr;
    assign irq_tx  = tdre & fl_q.tie;
    assign irq_rx  = (fl_q.rdrf | fl_q.orfe) & fl_q.rie;

    // overrun keeps the older data and raises the error flag
    assert_overrun_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done && rx_ok && accept && fl_q.rdrf) |=> (fl_q.orfe && $stable(fl_q.rdr)));

    // bad stop bit always raises the error flag, ninth bit or not
    assert_frame_err_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done && !rx_ok) |=> fl_q.orfe);

    // an address-gated frame with ninth bit 0 is ignored
    assert_ninth_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done && rx_ok && fl_q.m9 && !rx_frame[DW] && !rx_rd) |=>
        ($stable(fl_q.rdrf) && $stable(fl_q.rdr)));

    // error flag survives a data read that was not preceded by a status read
    assert_err_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_q.orfe && rx_rd && !fl_q.arm) |=> fl_q.orfe);

endmodule

// File: tb/sim_sfi_uart.sv
`timescale 1ns/1ps
module sim_sfi_uart;
    localparam int DW  = 8;
    localparam int OVS = 16;
    localparam int BIT_CYC = OVS * 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic baud_tick = 1'b0;
    logic ctrl_wr = 1'b0, ctrl_tie = 1'b0, ctrl_rie = 1'b0, ctrl_m9 = 1'b0;
    logic tx_wr = 1'b0;
    logic [DW:0] tx_data = '0;
    logic stat_rd = 1'b0, rx_rd = 1'b0;
    logic rxd = 1'b1;
    logic txd, tdre, rdrf, orfe, irq_tx, irq_rx;
    logic [DW:0] rx_data;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    logic early_rdrf, early_orfe;

    sfi_uart #(.DW(DW), .OVS(OVS)) u0 (
        .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick),
        .ctrl_wr(ctrl_wr), .ctrl_tie(ctrl_tie), .ctrl_rie(ctrl_rie), .ctrl_m9(ctrl_m9),
        .tx_wr(tx_wr), .tx_data(tx_data), .stat_rd(stat_rd), .rx_rd(rx_rd),
        .rxd(rxd), .txd(txd), .tdre(tdre), .rdrf(rdrf), .orfe(orfe),
        .rx_data(rx_data), .irq_tx(irq_tx), .irq_rx(irq_rx)
    );

    always #4 clk = ~clk;

    initial forever begin
        @(negedge clk);
        baud_tick = ~baud_tick;
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000) begin
            n_bad = n_bad + 1;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk = n_chk + 1;
        if (act != exp) begin
            n_bad = n_bad + 1;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic set_ctrl(input logic tie, input logic rie, input logic m9);
        ctrl_tie = tie; ctrl_rie = rie; ctrl_m9 = m9; ctrl_wr = 1'b1;
        @(negedge clk);
        ctrl_wr = 1'b0;
    endtask

    task automatic pulse_rx_rd();
        rx_rd = 1'b1;
        @(negedge clk);
        rx_rd = 1'b0;
    endtask

    task automatic pulse_stat_rd();
        stat_rd = 1'b1;
        @(negedge clk);
        stat_rd = 1'b0;
    endtask

    // drives one frame on rxd; a low stop bit is cut short so the line idles afterwards
    task automatic rx_frame(input logic [DW:0] d, input int nb, input logic stopv);
        rxd = 1'b0;
        wait_cyc(BIT_CYC);
        for (int i = 0; i < nb; i++) begin
            rxd = d[i];
            wait_cyc(BIT_CYC);
        end
        rxd = stopv;
        wait_cyc(4);
        early_rdrf = rdrf;
        early_orfe = orfe;
        if (stopv) begin
            wait_cyc(BIT_CYC - 4);
        end else begin
            wait_cyc(20);
            rxd = 1'b1;
            wait_cyc(BIT_CYC);
        end
        rxd = 1'b1;
        wait_cyc(4);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(1);
        chk("R1 tdre", int'(tdre), 1);
        chk("R1 rdrf", int'(rdrf), 0);
        chk("R1 orfe", int'(orfe), 0);
        chk("R1 irq_tx", int'(irq_tx), 0);
        chk("R1 irq_rx", int'(irq_rx), 0);
        chk("R1 txd", int'(txd), 1);
    endtask

    task automatic t_tx(input logic [DW:0] d, input int nb);
        tx_data = d;
        tx_wr = 1'b1;
        @(negedge clk);
        tx_wr = 1'b0;
        chk("R2 tdre after write", int'(tdre), 0);
        chk("R2 idle before move", int'(txd), 1);
        @(negedge clk);
        chk("R2 tdre after move", int'(tdre), 1);
        chk("R2 start bit", int'(txd), 0);
        wait_cyc(BIT_CYC / 2 - 1);
        chk("R3 start centre", int'(txd), 0);
        for (int i = 0; i < nb; i++) begin
            wait_cyc(BIT_CYC);
            chk($sformatf("R3 data bit %0d", i), int'(txd), int'(d[i]));
        end
        wait_cyc(BIT_CYC);
        chk("R3 stop bit", int'(txd), 1);
        wait_cyc(BIT_CYC);
        chk("R3 idle high", int'(txd), 1);
    endtask

    task automatic t_tx_irq();
        set_ctrl(1'b1, 1'b0, 1'b0);
        chk("R4 irq_tx when empty", int'(irq_tx), 1);
        tx_data = 9'h0F0;
        tx_wr = 1'b1;
        @(negedge clk);
        tx_wr = 1'b0;
        chk("R4 irq_tx while full", int'(irq_tx), 0);
        @(negedge clk);
        chk("R4 irq_tx after move", int'(irq_tx), 1);
        wait_cyc(BIT_CYC * 11);
        set_ctrl(1'b0, 1'b0, 1'b0);
        chk("R4 irq_tx disabled", int'(irq_tx), 0);
    endtask

    task automatic t_rx_good();
        set_ctrl(1'b0, 1'b1, 1'b0);
        chk("R11 irq_rx idle", int'(irq_rx), 0);
        rx_frame(9'h0A5, 8, 1'b1);
        chk("R5 rdrf not before stop", int'(early_rdrf), 0);
        chk("R5 rdrf set", int'(rdrf), 1);
        chk("R5 rx_data", int'(rx_data), 'h0A5);
        chk("R5 no error", int'(orfe), 0);
        chk("R11 irq_rx on rdrf", int'(irq_rx), 1);
        pulse_rx_rd();
        chk("R10 rdrf cleared", int'(rdrf), 0);
        chk("R11 irq_rx cleared", int'(irq_rx), 0);
    endtask

    task automatic t_overrun();
        rx_frame(9'h03C, 8, 1'b1);
        chk("R5 first frame", int'(rx_data), 'h03C);
        rx_frame(9'h0C3, 8, 1'b1);
        chk("R7 orfe not before stop", int'(early_orfe), 0);
        chk("R7 orfe on overrun", int'(orfe), 1);
        chk("R7 old data kept", int'(rx_data), 'h03C);
        chk("R7 rdrf still set", int'(rdrf), 1);
        pulse_rx_rd();
        chk("R10 rdrf cleared by read", int'(rdrf), 0);
        chk("R10 orfe kept without status read", int'(orfe), 1);
        chk("R11 irq_rx on orfe", int'(irq_rx), 1);
        pulse_stat_rd();
        chk("R10 orfe kept after status only", int'(orfe), 1);
        pulse_rx_rd();
        chk("R10 orfe cleared", int'(orfe), 0);
        chk("R11 irq_rx low", int'(irq_rx), 0);
    endtask

    task automatic t_framing();
        rx_frame(9'h055, 8, 1'b0);
        chk("R6 orfe set", int'(orfe), 1);
        chk("R6 rdrf unchanged", int'(rdrf), 0);
        chk("R6 data unchanged", int'(rx_data), 'h03C);
        pulse_stat_rd();
        pulse_rx_rd();
        chk("R10 orfe cleared after framing", int'(orfe), 0);
    endtask

    task automatic t_glitch();
        rxd = 1'b0;
        wait_cyc(6);
        rxd = 1'b1;
        wait_cyc(BIT_CYC * 11);
        chk("R12 glitch no rdrf", int'(rdrf), 0);
        chk("R12 glitch no orfe", int'(orfe), 0);
        rx_frame(9'h081, 8, 1'b1);
        chk("R12 frame after glitch", int'(rx_data), 'h081);
        pulse_rx_rd();
    endtask

    task automatic t_mode9();
        set_ctrl(1'b0, 1'b1, 1'b1);
        rx_frame(9'h0E7, 9, 1'b1);
        chk("R8 ninth 0 no rdrf", int'(rdrf), 0);
        chk("R8 ninth 0 data unchanged", int'(rx_data), 'h081);
        chk("R8 ninth 0 no irq", int'(irq_rx), 0);
        rx_frame(9'h12D, 9, 1'b1);
        chk("R8 ninth 1 rdrf", int'(rdrf), 1);
        chk("R8 ninth 1 data", int'(rx_data), 'h12D);
        pulse_rx_rd();
        rx_frame(9'h042, 9, 1'b0);
        chk("R9 framing with ninth 0", int'(orfe), 1);
        chk("R9 rdrf unchanged", int'(rdrf), 0);
        pulse_stat_rd();
        pulse_rx_rd();
        t_tx(9'h155, 9);
        set_ctrl(1'b0, 1'b0, 1'b0);
    endtask

    initial begin
        t_reset();
        t_tx(9'h0A5, 8);
        t_tx(9'h03C, 8);
        t_tx_irq();
        t_rx_good();
        t_overrun();
        t_framing();
        t_glitch();
        t_mode9();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule